// File: doc/BRIEF.md
# Reset Source and Recovery Controller

This block sequences system reset for a small microcontroller. It collects reset requests from several places: a filtered active-low external pin, the power-on, brownout and watchdog detectors, a debugger request bit and a wake event from STOP mode. It picks one cause, holds the right parts of the chip in reset for a programmable time and then releases the core into a two-cycle reset-vector fetch.

Each cause resets a different set of logic. An internal cause (power-on, brownout, watchdog) resets everything. It also pulls the shared reset pin low through an open-drain enable, so that parts on the board reset with the chip. A debugger request resets everything except the debugger logic, and the block sends back a one-cycle pulse that clears the request bit. STOP recovery holds only the CPU. Its hold is short when the crystal is off and long when it is on, and it forces the internal oscillator to be enabled and selected. A cause register records what started the last reset.

Top module: `rst_recovery_ctrl`

## Requirements
- R1: While `rst` is high and for POST_DLY (default 16) cycles after it falls, `core_rst`, `sys_rst`, `dbg_rst` and `pin_drive_en` are high and `cause` reads 5'b00001.
- R2: `ext_rst_n` passes through a two-flop synchronizer. A low level seen on 4 consecutive synchronized cycles starts a reset and sets `cause` to 5'b01000. A low pulse of 3 cycles or fewer has no effect.
- R3: After an external-pin reset, `core_rst` stays high for at least POST_DLY cycles, and for as long as the synchronized pin is still low. It falls on the first cycle after both conditions end.
- R4: A power-on, brownout or watchdog request holds `core_rst`, `sys_rst` and `dbg_rst` high for POST_DLY cycles. `pin_drive_en` is high for exactly those cycles and is never high for any other cause.
- R5: A debugger request (`dbg_req`) raises `core_rst` and `sys_rst` but keeps `dbg_rst` low. `dbg_req_clr` pulses for one cycle in the first reset cycle, and `cause` reads 5'b00001 (power-on bit).
- R6: `stop_wake` holds only `core_rst` high (with `sys_rst`, `dbg_rst` and `pin_drive_en` low). The hold lasts STOP_IPO_DLY (66) cycles if `xtal_en` was 0 at the wake, or STOP_XTAL_DLY (5000) cycles if it was 1. `osc_force_ipo` pulses for one cycle at the start, and `cause` reads 5'b10000.
- R7: `cause` has exactly one bit set. Bit 0 is power-on or debugger, bit 1 brownout, bit 2 watchdog, bit 3 external pin, bit 4 STOP. Requests that arrive together are ranked power-on, brownout, watchdog, external, debugger, STOP.
- R8: When `core_rst` falls, `vec_fetch` is high for two cycles, with `vec_addr` 16'h0002 and then 16'h0003. At all other times `vec_addr` is 0.
- R9: Requests that arrive while `core_rst` is high are ignored, and `cause` keeps its value until a new reset starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-up initialisation |
| ext_rst_n | input | 1 | External reset pin level, active low, asynchronous |
| por_req | input | 1 | Power-on reset request |
| bo_req | input | 1 | Brownout reset request |
| wdt_req | input | 1 | Watchdog reset request |
| dbg_req | input | 1 | Debugger reset request bit |
| stop_wake | input | 1 | STOP-mode wake event |
| xtal_en | input | 1 | Crystal oscillator enabled flag |
| core_rst | output | 1 | CPU reset |
| sys_rst | output | 1 | Reset for all logic except the debugger |
| dbg_rst | output | 1 | Reset for the debugger logic |
| pin_drive_en | output | 1 | Open-drain enable that pulls the reset pin low |
| cause | output | 5 | One-hot cause of the last reset |
| dbg_req_clr | output | 1 | One-cycle clear pulse for the debugger request bit |
| osc_force_ipo | output | 1 | One-cycle pulse that selects the internal oscillator |
| vec_fetch | output | 1 | Reset-vector fetch request |
| vec_addr | output | 16 | Program memory address of the vector fetch |

## Verification
External pin pulses of 3 and 4 cycles, and a level held well past the post-reset delay, separate the filter threshold from the pin-wait extension. A single pulse of each internal source, a held debugger request and STOP wakes with the crystal off and on show which reset outputs each cause drives and how long it lasts. Requests raised together check the ranking. Requests raised inside a hold show that they are ignored and that the cause register keeps its value.

// File: rtl/rsc_pkg.sv
`timescale 1ns/1ps
package rsc_pkg;

    localparam int CAUSE_W = 5;
    localparam int NREQ    = 6;

    localparam int C_POR  = 0;
    localparam int C_BO   = 1;
    localparam int C_WDT  = 2;
    localparam int C_EXT  = 3;
    localparam int C_STOP = 4;

    localparam logic [15:0] VEC_ADDR_LO = 16'h0002;
    localparam logic [15:0] VEC_ADDR_HI = 16'h0003;

    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_POR  = 3'd1,
        SRC_BO   = 3'd2,
        SRC_WDT  = 3'd3,
        SRC_EXT  = 3'd4,
        SRC_DBG  = 3'd5,
        SRC_STOP = 3'd6
    } src_e;

    typedef enum logic [2:0] {
        PH_RUN     = 3'd0,
        PH_HOLD    = 3'd1,
        PH_PINWAIT = 3'd2,
        PH_VEC_LO  = 3'd3,
        PH_VEC_HI  = 3'd4
    } phase_e;

    typedef logic [CAUSE_W-1:0] cause_t;

    typedef struct packed {
        logic hit;
        src_e src;
    } pick_t;

    // Request slot i (0 = highest priority) maps to source i+1.
    function automatic src_e src_of_slot(input int unsigned slot);
        return src_e'(3'(slot + 1));
    endfunction

    function automatic cause_t cause_of(input src_e s);
        cause_t c;
        c = '0;
        case (s)
            SRC_POR, SRC_DBG: c[C_POR]  = 1'b1;
            SRC_BO:           c[C_BO]   = 1'b1;
            SRC_WDT:          c[C_WDT]  = 1'b1;
            SRC_EXT:          c[C_EXT]  = 1'b1;
            SRC_STOP:         c[C_STOP] = 1'b1;
            default:          c         = '0;
        endcase
        return c;
    endfunction

    function automatic logic drives_pin(input src_e s);
        return (s == SRC_POR) || (s == SRC_BO) || (s == SRC_WDT);
    endfunction

endpackage

// File: rtl/rsc_pin_filter.sv
`timescale 1ns/1ps
module rsc_pin_filter #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FILT_LEN    = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic evt,
    output logic pin_low
);
    localparam int CNT_W = $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   pin_s;
    logic [CNT_W-1:0]       low_cnt;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= pin_n;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
            end
        end
    endgenerate

    assign pin_s = sync_q[SYNC_STAGES-1];

    // Saturating count of consecutive low synchronized samples.
    always_ff @(posedge clk) begin
        if (rst || pin_s)
            low_cnt <= '0;
        else if (low_cnt != CNT_W'(FILT_LEN))
            low_cnt <= low_cnt + 1'b1;
    end

    // One event on the FILT_LEN-th low sample; a held pin does not re-fire.
    assign evt     = !pin_s && (low_cnt == CNT_W'(FILT_LEN - 1));
    assign pin_low = !pin_s;

endmodule

// File: rtl/rsc_cause_arb.sv
`timescale 1ns/1ps
module rsc_cause_arb
    import rsc_pkg::*;
(
    input  logic [NREQ-1:0] req_vec,
    output pick_t           pick
);
    always_comb begin
        pick.hit = 1'b0;
        pick.src = SRC_NONE;
        for (int i = NREQ - 1; i >= 0; i--) begin
            if (req_vec[i]) begin
                pick.hit = 1'b1;
                pick.src = src_of_slot(i);
            end
        end
    end
endmodule

// File: rtl/rsc_seq_fsm.sv
`timescale 1ns/1ps
module rsc_seq_fsm
    import rsc_pkg::*;
#(
    parameter int unsigned POST_DLY      = 16,
    parameter int unsigned STOP_IPO_DLY  = 66,
    parameter int unsigned STOP_XTAL_DLY = 5000
) (
    input  logic   clk,
    input  logic   rst,
    input  pick_t  pick,
    input  logic   xtal_en,
    input  logic   pin_low,
    output phase_e phase,
    output src_e   src,
    output cause_t cause,
    output logic   fresh
);
    localparam int unsigned MAX_A   = (POST_DLY > STOP_IPO_DLY) ? POST_DLY : STOP_IPO_DLY;
    localparam int unsigned MAX_DLY = (MAX_A > STOP_XTAL_DLY) ? MAX_A : STOP_XTAL_DLY;
    localparam int          CNT_W   = $clog2(MAX_DLY + 1);

    logic [CNT_W-1:0] left;
    logic [CNT_W-1:0] load_val;
    logic             open_win;
    logic             accept;

    assign open_win = (phase == PH_RUN) || (phase == PH_VEC_LO) || (phase == PH_VEC_HI);
    assign accept   = open_win && pick.hit;

    always_comb begin
        if (pick.src == SRC_STOP)
            load_val = xtal_en ? CNT_W'(STOP_XTAL_DLY - 1) : CNT_W'(STOP_IPO_DLY - 1);
        else
            load_val = CNT_W'(POST_DLY - 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_HOLD;
            left  <= CNT_W'(POST_DLY - 1);
            src   <= SRC_POR;
            cause <= cause_of(SRC_POR);
            fresh <= 1'b1;
        end else begin
            fresh <= 1'b0;
            if (accept) begin
                phase <= PH_HOLD;
                left  <= load_val;
                src   <= pick.src;
                cause <= cause_of(pick.src);
                fresh <= 1'b1;
            end else begin
                case (phase)
                    PH_HOLD: begin
                        if (left == '0)
                            phase <= (src == SRC_EXT && pin_low) ? PH_PINWAIT : PH_VEC_LO;
                        else
                            left <= left - 1'b1;
                    end
                    PH_PINWAIT: if (!pin_low) phase <= PH_VEC_LO;
                    PH_VEC_LO:  phase <= PH_VEC_HI;
                    default:    phase <= PH_RUN;
                endcase
            end
        end
    end
endmodule

// File: rtl/rst_recovery_ctrl.sv
`timescale 1ns/1ps
module rst_recovery_ctrl
    import rsc_pkg::*;
#(
    parameter int unsigned FILT_LEN      = 4,
    parameter int unsigned POST_DLY      = 16,
    parameter int unsigned STOP_IPO_DLY  = 66,
    parameter int unsigned STOP_XTAL_DLY = 5000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ext_rst_n,
    input  logic        por_req,
    input  logic        bo_req,
    input  logic        wdt_req,
    input  logic        dbg_req,
    input  logic        stop_wake,
    input  logic        xtal_en,
    output logic        core_rst,
    output logic        sys_rst,
    output logic        dbg_rst,
    output logic        pin_drive_en,
    output logic [4:0]  cause,
    output logic        dbg_req_clr,
    output logic        osc_force_ipo,
    output logic        vec_fetch,
    output logic [15:0] vec_addr
);
    logic            ext_evt;
    logic            ext_low;
    logic [NREQ-1:0] req_vec;
    pick_t           pick;
    phase_e          phase;
    src_e            src;
    cause_t          cause_q;
    logic            fresh;

    rsc_pin_filter #(
        .SYNC_STAGES (2),
        .FILT_LEN    (FILT_LEN)
    ) u_filter (
        .clk     (clk),
        .rst     (rst),
        .pin_n   (ext_rst_n),
        .evt     (ext_evt),
        .pin_low (ext_low)
    );

    // Slot order is the priority order (slot 0 wins).
    assign req_vec = {stop_wake, dbg_req, ext_evt, wdt_req, bo_req, por_req};

    rsc_cause_arb u_arb (
        .req_vec (req_vec),
        .pick    (pick)
    );

    rsc_seq_fsm #(
        .POST_DLY      (POST_DLY),
        .STOP_IPO_DLY  (STOP_IPO_DLY),
        .STOP_XTAL_DLY (STOP_XTAL_DLY)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .pick    (pick),
        .xtal_en (xtal_en),
        .pin_low (ext_low),
        .phase   (phase),
        .src     (src),
        .cause   (cause_q),
        .fresh   (fresh)
    );

    assign core_rst      = (phase == PH_HOLD) || (phase == PH_PINWAIT);
    assign sys_rst       = core_rst && (src != SRC_STOP);
    assign dbg_rst       = sys_rst && (src != SRC_DBG);
    assign pin_drive_en  = (phase == PH_HOLD) && drives_pin(src);
    assign dbg_req_clr   = fresh && (src == SRC_DBG);
    assign osc_force_ipo = fresh && (src == SRC_STOP);
    assign vec_fetch     = (phase == PH_VEC_LO) || (phase == PH_VEC_HI);
    assign vec_addr      = (phase == PH_VEC_LO) ? VEC_ADDR_LO :
                           (phase == PH_VEC_HI) ? VEC_ADDR_HI : 16'h0000;
    assign cause         = cause_q;

endmodule

// File: rtl/rsc_checker.sv
`timescale 1ns/1ps
module rsc_checker
    import rsc_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        core_rst,
    input logic        sys_rst,
    input logic        dbg_rst,
    input logic        pin_drive_en,
    input logic [4:0]  cause,
    input logic        dbg_req_clr,
    input logic        osc_force_ipo,
    input logic        vec_fetch,
    input logic [15:0] vec_addr
);
    // R4: the pin is pulled only while the whole chip is in reset
    p_pin_full_reset_r4: assert property (@(posedge clk) disable iff (rst)
        pin_drive_en |-> (core_rst && sys_rst && dbg_rst));

    // R5: clear pulse only in a debugger reset, and lasts one cycle
    p_dbg_clr_scope_r5: assert property (@(posedge clk) disable iff (rst)
        dbg_req_clr |-> (core_rst && sys_rst && !dbg_rst));
    p_dbg_clr_single_r5: assert property (@(posedge clk) disable iff (rst)
        dbg_req_clr |=> !dbg_req_clr);

    // R6: STOP hold touches only the core
    p_stop_core_only_r6: assert property (@(posedge clk) disable iff (rst)
        (core_rst && !sys_rst) |-> (!dbg_rst && !pin_drive_en && cause == 5'b10000));
    p_osc_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        osc_force_ipo |-> (core_rst && !sys_rst));

    // R7: exactly one cause bit
    p_cause_onehot_r7: assert property (@(posedge clk) disable iff (rst)
        $countones(cause) == 1);

    // R8: release leads into the two-address vector fetch
    p_release_fetch_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(core_rst) |-> (vec_fetch && vec_addr == VEC_ADDR_LO));
    p_fetch_order_r8: assert property (@(posedge clk) disable iff (rst)
        (vec_fetch && vec_addr == VEC_ADDR_LO) |=> (vec_fetch && vec_addr == VEC_ADDR_HI));

    // R9: cause frozen while reset is active
    p_cause_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (core_rst && $past(core_rst)) |-> $stable(cause));
endmodule

bind rst_recovery_ctrl rsc_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .core_rst      (core_rst),
    .sys_rst       (sys_rst),
    .dbg_rst       (dbg_rst),
    .pin_drive_en  (pin_drive_en),
    .cause         (cause),
    .dbg_req_clr   (dbg_req_clr),
    .osc_force_ipo (osc_force_ipo),
    .vec_fetch     (vec_fetch),
    .vec_addr      (vec_addr)
);

// File: tb/rst_recovery_ctrl_tb_top.sv
`timescale 1ns/1ps
module rst_recovery_ctrl_tb_top;

    localparam int POST   = 16;
    localparam int S_IPO  = 66;
    localparam int S_XTAL = 5000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_rst_n = 1'b1;
    logic        por_req = 1'b0, bo_req = 1'b0, wdt_req = 1'b0;
    logic        dbg_req = 1'b0, stop_wake = 1'b0, xtal_en = 1'b0;
    logic        core_rst, sys_rst, dbg_rst, pin_drive_en;
    logic [4:0]  cause;
    logic        dbg_req_clr, osc_force_ipo, vec_fetch;
    logic [15:0] vec_addr;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    rst_recovery_ctrl #(
        .FILT_LEN(4), .POST_DLY(POST), .STOP_IPO_DLY(S_IPO), .STOP_XTAL_DLY(S_XTAL)
    ) dut_i (
        .clk(clk), .rst(rst), .ext_rst_n(ext_rst_n), .por_req(por_req), .bo_req(bo_req),
        .wdt_req(wdt_req), .dbg_req(dbg_req), .stop_wake(stop_wake), .xtal_en(xtal_en),
        .core_rst(core_rst), .sys_rst(sys_rst), .dbg_rst(dbg_rst), .pin_drive_en(pin_drive_en),
        .cause(cause), .dbg_req_clr(dbg_req_clr), .osc_force_ipo(osc_force_ipo),
        .vec_fetch(vec_fetch), .vec_addr(vec_addr)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    // mode: 0 running, 1 timed hold, 2 waiting for pin, 3/4 vector fetch
    int mode, remain, who, m_cause, p1, p2, lows;
    bit first;

    function automatic int bit_for(input int w);
        case (w)
            1, 5: return 1;
            2: return 2;
            3: return 4;
            4: return 8;
            6: return 16;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            mode = 1; remain = POST - 1; who = 1; m_cause = 1; first = 1;
            p1 = 1; p2 = 1; lows = 0;
        end else begin
            int pick;
            bit evt, low_now;
            evt     = (p2 == 0) && (lows == 3);
            low_now = (p2 == 0);
            lows    = (p2 == 0) ? ((lows < 4) ? lows + 1 : 4) : 0;
            p2      = p1;
            p1      = ext_rst_n;
            first   = 0;
            if (por_req)        pick = 1;
            else if (bo_req)    pick = 2;
            else if (wdt_req)   pick = 3;
            else if (evt)       pick = 4;
            else if (dbg_req)   pick = 5;
            else if (stop_wake) pick = 6;
            else                pick = 0;
            if (mode == 0 || mode == 3 || mode == 4) begin
                if (pick != 0) begin
                    mode = 1; who = pick; m_cause = bit_for(pick); first = 1;
                    remain = (pick == 6) ? (xtal_en ? S_XTAL - 1 : S_IPO - 1) : POST - 1;
                end else begin
                    mode = (mode == 3) ? 4 : 0;
                end
            end else if (mode == 1) begin
                if (remain == 0) mode = (who == 4 && low_now) ? 2 : 3;
                else remain--;
            end else if (!low_now) begin
                mode = 3;
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            bit e_core, e_sys, e_dbg, e_pin;
            int e_addr;
            e_core = (mode == 1 || mode == 2);
            e_sys  = e_core && who != 6;
            e_dbg  = e_sys && who != 5;
            e_pin  = (mode == 1) && (who >= 1 && who <= 3);
            e_addr = (mode == 3) ? 2 : (mode == 4) ? 3 : 0;
            chk(core_rst === e_core, "R3 core_rst", int'(core_rst), int'(e_core));
            chk(sys_rst === e_sys, "R6 sys_rst", int'(sys_rst), int'(e_sys));
            chk(dbg_rst === e_dbg, "R5 dbg_rst", int'(dbg_rst), int'(e_dbg));
            chk(pin_drive_en === e_pin, "R4 pin_drive_en", int'(pin_drive_en), int'(e_pin));
            chk(dbg_req_clr === (first && who == 5), "R5 dbg_req_clr", int'(dbg_req_clr), int'(first && who == 5));
            chk(osc_force_ipo === (first && who == 6), "R6 osc_force_ipo", int'(osc_force_ipo), int'(first && who == 6));
            chk(vec_fetch === (mode == 3 || mode == 4), "R8 vec_fetch", int'(vec_fetch), int'(mode == 3 || mode == 4));
            chk(vec_addr === 16'(e_addr), "R8 vec_addr", int'(vec_addr), e_addr);
            chk(cause === 5'(m_cause), "R7 cause", int'(cause), m_cause);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk); sig = 1'b1;
        @(negedge clk); sig = 1'b0;
    endtask

    // Waits for core_rst, then counts the negedges that see it and pin_drive_en high.
    task automatic measure_hold(output int n_core, output int n_pin);
        int guard = 0;
        n_core = 0; n_pin = 0;
        while (core_rst !== 1'b1 && guard < 20) begin @(negedge clk); guard++; end
        while (core_rst === 1'b1 && n_core < 20000) begin
            n_core++;
            if (pin_drive_en === 1'b1) n_pin++;
            @(negedge clk);
        end
    endtask

    task automatic check_fetch(input string tag);
        chk(vec_fetch === 1'b1 && vec_addr === 16'h0002, tag, int'(vec_addr), 2);
        @(negedge clk);
        chk(vec_fetch === 1'b1 && vec_addr === 16'h0003, tag, int'(vec_addr), 3);
    endtask

    initial begin
        int nc, np;
        bool_dummy: begin end
        // R1: power-up sequence
        step(3);
        chk(core_rst === 1'b1 && cause === 5'b00001, "R1 reset state", int'(cause), 1);
        rst = 1'b0;
        measure_hold(nc, np);
        chk(nc == POST, "R1 hold length", nc, POST);
        chk(np == POST, "R1 pin length", np, POST);
        check_fetch("R8 fetch after power-up");
        step(4);

        // R4: watchdog
        pulse(wdt_req);
        measure_hold(nc, np);
        chk(nc == POST && np == POST, "R4 watchdog hold", nc, POST);
        chk(cause === 5'b00100, "R4 watchdog cause", int'(cause), 4);
        check_fetch("R8 fetch after watchdog");
        step(4);

        // R2: three-cycle pulse ignored
        @(negedge clk); ext_rst_n = 1'b0;
        step(3); ext_rst_n = 1'b1;
        nc = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (core_rst !== 1'b0) nc++;
        end
        chk(nc == 0, "R2 short pulse ignored", nc, 0);
        chk(cause === 5'b00100, "R2 cause unchanged", int'(cause), 4);

        // R2: four-cycle pulse accepted
        @(negedge clk); ext_rst_n = 1'b0;
        step(4); ext_rst_n = 1'b1;
        measure_hold(nc, np);
        chk(nc == POST && np == 0, "R2 four-cycle pulse", nc, POST);
        chk(cause === 5'b01000, "R2 external cause", int'(cause), 8);
        step(4);

        // R3: pin held past the delay
        @(negedge clk); ext_rst_n = 1'b0;
        step(45);
        chk(core_rst === 1'b1, "R3 held in reset", int'(core_rst), 1);
        ext_rst_n = 1'b1;
        step(1);
        chk(core_rst === 1'b1, "R3 sync delay after release", int'(core_rst), 1);
        measure_hold(nc, np);
        check_fetch("R8 fetch after pin wait");
        step(4);

        // R5: debugger request
        @(negedge clk); dbg_req = 1'b1;
        nc = 0;
        while (dbg_req_clr !== 1'b1 && nc < 10) begin @(negedge clk); nc++; end
        chk(dbg_req_clr === 1'b1 && sys_rst === 1'b1 && dbg_rst === 1'b0, "R5 debugger scope",
            int'(dbg_rst), 0);
        dbg_req = 1'b0;
        measure_hold(nc, np);
        chk(cause === 5'b00001 && np == 0, "R5 debugger cause", int'(cause), 1);
        step(4);

        // R6: STOP recovery, crystal off and on
        xtal_en = 1'b0;
        pulse(stop_wake);
        measure_hold(nc, np);
        chk(nc == S_IPO, "R6 stop hold crystal off", nc, S_IPO);
        chk(cause === 5'b10000, "R6 stop cause", int'(cause), 16);
        step(4);
        xtal_en = 1'b1;
        pulse(stop_wake);
        xtal_en = 1'b0;
        measure_hold(nc, np);
        chk(nc == S_XTAL, "R6 stop hold crystal on", nc, S_XTAL);
        step(4);

        // R7: simultaneous requests
        @(negedge clk); bo_req = 1'b1; wdt_req = 1'b1; stop_wake = 1'b1;
        @(negedge clk); bo_req = 1'b0; wdt_req = 1'b0; stop_wake = 1'b0;
        chk(cause === 5'b00010 && pin_drive_en === 1'b1, "R7 brownout wins", int'(cause), 2);

        // R9: requests inside the hold are ignored
        step(3);
        pulse(wdt_req);
        pulse(stop_wake);
        measure_hold(nc, np);
        chk(cause === 5'b00010, "R9 cause kept", int'(cause), 2);
        chk(osc_force_ipo === 1'b0 && core_rst === 1'b0, "R9 no retrigger", int'(core_rst), 0);
        step(4);

        // R7: debugger against STOP
        @(negedge clk); dbg_req = 1'b1; stop_wake = 1'b1;
        @(negedge clk); dbg_req = 1'b0; stop_wake = 1'b0;
        chk(cause === 5'b00001 && dbg_req_clr === 1'b1, "R7 debugger over stop", int'(cause), 1);
        measure_hold(nc, np);

        // R4: power-on request
        step(4);
        pulse(por_req);
        measure_hold(nc, np);
        chk(np == POST, "R4 power-on pin drive", np, POST);
        step(4);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule